// File: doc/BRIEF.md
# Width-Packing Transfer Buffer

This block sits in a DMA data path between a memory side that always moves full 32-bit words and a peripheral port that moves either 8-bit or 16-bit items. When data flows toward the device, whole words are loaded from memory into an internal word store. They are then handed out one item at a time. When data flows toward memory, device items are gathered lane by lane into a staging word. Only completed words enter the store, and they are offered to memory from there.

A direction input picks which of the two flows is live, and the ports of the idle flow stay quiet. A width input picks byte or half-word items. A lane-order input picks whether the first item of a word occupies the low end or the high end of that word. A flush input abandons the word that is in progress and returns the lane pointer to the start. Address generation and burst sequencing belong to the surrounding controller.

Lane position is tracked by a two-state machine. ST_WORD_START means no item of the current word has moved yet. ST_WORD_MID means at least one item has moved. The transitions are:

- first-item: a device handshake in ST_WORD_START moves to ST_WORD_MID.
- next-item: a device handshake on a lane that is not the last stays in ST_WORD_MID.
- word-done: a handshake on the last lane returns to ST_WORD_START.
- flush-abandon: a flush in ST_WORD_MID returns to ST_WORD_START.
- flush-idle: a flush in ST_WORD_START stays in ST_WORD_START.

Top module: `width_pack_buffer`

## Requirements
- R1: After reset the store is empty and the lane pointer is at item 0. With dir=0, mem_in_ready is 1 and dev_out_valid, mem_out_valid and dev_in_ready are 0. With dir=1, dev_in_ready is 1 and mem_in_ready is 0.
- R2: Toward the device (dir=0) in byte mode (half_mode=0) with big_endian=0, item k of a word is word bits [8k+7:8k]. It is presented on dev_out_data[7:0], with dev_out_data[15:8] equal to 0.
- R3: Toward the device in byte mode with big_endian=1, item k of a word is word bits [31-8k:24-8k]. It is presented on dev_out_data[7:0], with the upper byte equal to 0.
- R4: Toward the device in half-word mode (half_mode=1), a word yields two items. With big_endian=0 the first item is bits [15:0] and the second is [31:16]. With big_endian=1 the order is reversed.
- R5: Toward memory (dir=1) in byte mode, four items make one word. dev_in_data[7:0] of item k lands in bits [8k+7:8k] when big_endian=0, and in bits [31-8k:24-8k] when big_endian=1. dev_in_data[15:8] is ignored. No word is offered on mem_out before the fourth item is taken.
- R6: Toward memory in half-word mode, two items make one word. The first item lands in [15:0] when big_endian=0 and in [31:16] when big_endian=1. No word is offered before the second item is taken.
- R7: The store holds DEPTH (default 8) words. When it is full, mem_in_ready is 0 (dir=0) and dev_in_ready is 0 (dir=1).
- R8: When the store is empty, dev_out_valid is 0 (dir=0) and mem_out_valid is 0 (dir=1).
- R9: Toward memory, a flush discards the partly gathered word. The next word offered is built only from items taken after the flush. dev_in_ready is 0 during the flush cycle.
- R10: Toward the device, a flush while part of the head word has been sent drops that word, and the next item is item 0 of the following word. A flush at item 0 leaves the head word intact. dev_out_valid is 0 during the flush cycle.
- R11: Words leave the store in the order they entered it, and items leave in lane order within each word.
- R12: While dev_out_valid is 1 and dev_out_ready is 0, dev_out_data is held unchanged, as long as no flush occurs and none of the mode inputs change.
- R13: With dir=0, mem_out_valid and dev_in_ready stay 0. With dir=1, mem_in_ready and dev_out_valid stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dir | input | 1 | 0: memory to device, 1: device to memory |
| half_mode | input | 1 | 0: byte items, 1: half-word items |
| big_endian | input | 1 | 0: first item at the low end of the word, 1: first item at the high end |
| flush | input | 1 | Abandon the word in progress and reset the lane pointer |
| mem_in_valid | input | 1 | Word from memory is valid |
| mem_in_ready | output | 1 | Store accepts a word from memory |
| mem_in_data | input | 32 | Word from memory |
| mem_out_valid | output | 1 | Completed word available for memory |
| mem_out_ready | input | 1 | Memory side takes the word |
| mem_out_data | output | 32 | Completed word toward memory |
| dev_out_valid | output | 1 | Item for the device is valid |
| dev_out_ready | input | 1 | Device takes the item |
| dev_out_data | output | 16 | Item toward the device (byte items zero-extended) |
| dev_in_valid | input | 1 | Item from the device is valid |
| dev_in_ready | output | 1 | Block accepts a device item |
| dev_in_data | input | 16 | Item from the device (byte items use bits [7:0]) |

## Verification
Both directions are swept over all four combinations of item width and lane order, pushing enough words to fill the store completely. Each sweep tells apart the lane mapping of each mode and confirms that ordering is preserved across a full store.

Device items carry a deliberately non-zero upper byte in byte mode, so that any leak of ignored bits into the packed word shows up. A fill count read while the store is partly full separates word-granular release from item-granular release.

The flush tests are run at the start of a word and in the middle of a word. This separates dropping the head word from keeping it. A stall window separates held output data from data that drifts while the device is not ready.

// File: rtl/dwp_pkg.sv
package dwp_pkg;

    localparam int WORD_W  = 32;
    localparam int ITEM_W  = 16;
    localparam int LANES_W = 2;

    typedef enum logic {
        DIR_TO_DEV = 1'b0,
        DIR_TO_MEM = 1'b1
    } dir_e;

    typedef enum logic {
        ST_WORD_START = 1'b0,
        ST_WORD_MID   = 1'b1
    } lane_state_e;

    // Map an item index within a word to its lane slot in the word.
    // Byte mode: slot counts bytes. Half-word mode: slot[0] selects the half.
    function automatic logic [LANES_W-1:0] lane_slot(
        input logic [LANES_W-1:0] idx,
        input logic               half,
        input logic               be
    );
        if (half)
            return be ? {1'b0, ~idx[0]} : {1'b0, idx[0]};
        else
            return be ? (2'd3 - idx) : idx;
    endfunction

endpackage

// File: rtl/dwp_word_fifo.sv
module dwp_word_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [W-1:0]                 wdata,
    input  logic                         pop,
    output logic [W-1:0]                 rdata,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         full,
    output logic                         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH+1);
    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic [W-1:0]  store [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;

    always_ff @(posedge clk) begin
        if (push)
            store[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push)
                wr_ptr <= (wr_ptr == LAST_IDX) ? '0 : wr_ptr + 1'b1;
            if (pop)
                rd_ptr <= (rd_ptr == LAST_IDX) ? '0 : rd_ptr + 1'b1;
            unique case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign rdata = store[rd_ptr];
    assign full  = (count == FULL_CNT);
    assign empty = (count == '0);

endmodule

// File: rtl/dwp_unpacker.sv
module dwp_unpacker
    import dwp_pkg::*;
(
    input  logic [WORD_W-1:0]  word,
    input  logic [LANES_W-1:0] slot,
    input  logic               half,
    output logic [ITEM_W-1:0]  item
);
    always_comb begin
        if (half)
            item = word[{slot[0], 4'b0000} +: 16];
        else
            item = {8'h00, word[{slot, 3'b000} +: 8]};
    end
endmodule

// File: rtl/dwp_packer.sv
module dwp_packer
    import dwp_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               load,
    input  logic               last,
    input  logic               half,
    input  logic [LANES_W-1:0] slot,
    input  logic [ITEM_W-1:0]  item,
    output logic [WORD_W-1:0]  merged
);
    localparam int BYTES = WORD_W / 8;

    logic [WORD_W-1:0] acc;

    // Each byte lane takes the incoming item byte when the slot addresses it.
    for (genvar b = 0; b < BYTES; b++) begin : g_lane
        localparam logic [LANES_W-1:0] BI = LANES_W'(b);
        localparam int HB = b % 2;
        logic hit;
        assign hit = half ? (slot[0] == BI[1]) : (slot == BI);
        assign merged[8*b +: 8] = hit ? (half ? item[8*HB +: 8] : item[7:0])
                                      : acc[8*b +: 8];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            acc <= '0;
        else if (clear || (load && last))
            acc <= '0;
        else if (load)
            acc <= merged;
    end
endmodule

// File: rtl/width_pack_buffer.sv
module width_pack_buffer
    import dwp_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               dir,
    input  logic               half_mode,
    input  logic               big_endian,
    input  logic               flush,
    input  logic               mem_in_valid,
    output logic               mem_in_ready,
    input  logic [WORD_W-1:0]  mem_in_data,
    output logic               mem_out_valid,
    input  logic               mem_out_ready,
    output logic [WORD_W-1:0]  mem_out_data,
    output logic               dev_out_valid,
    input  logic               dev_out_ready,
    output logic [ITEM_W-1:0]  dev_out_data,
    input  logic               dev_in_valid,
    output logic               dev_in_ready,
    input  logic [ITEM_W-1:0]  dev_in_data
);
    localparam int CW = $clog2(DEPTH+1);

    lane_state_e        state_q, state_d;
    logic [LANES_W-1:0] lane_q, lane_d;
    logic [LANES_W-1:0] slot;
    logic               last_lane;
    logic               to_dev;

    logic               fifo_push, fifo_pop, fifo_full, fifo_empty;
    logic [WORD_W-1:0]  fifo_wdata, fifo_head, packed_word;
    logic [CW-1:0]      fill_count;

    logic               dev_fire_out, dev_fire_in, dev_fire;

    assign to_dev    = (dir == DIR_TO_DEV);
    assign slot      = lane_slot(lane_q, half_mode, big_endian);
    assign last_lane = half_mode ? (lane_q == 2'd1) : (lane_q == 2'd3);

    dwp_word_fifo #(.DEPTH(DEPTH), .W(WORD_W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (fifo_push),
        .wdata (fifo_wdata),
        .pop   (fifo_pop),
        .rdata (fifo_head),
        .count (fill_count),
        .full  (fifo_full),
        .empty (fifo_empty)
    );

    dwp_unpacker u_unpack (
        .word (fifo_head),
        .slot (slot),
        .half (half_mode),
        .item (dev_out_data)
    );

    dwp_packer u_pack (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (flush),
        .load   (dev_fire_in),
        .last   (last_lane),
        .half   (half_mode),
        .slot   (slot),
        .item   (dev_in_data),
        .merged (packed_word)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_WORD_START;
            lane_q  <= '0;
        end else begin
            state_q <= state_d;
            lane_q  <= lane_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        lane_d  = lane_q;
        unique case (state_q)
            ST_WORD_START: begin
                if (!flush && dev_fire) begin
                    state_d = ST_WORD_MID;
                    lane_d  = 2'd1;
                end
            end
            ST_WORD_MID: begin
                if (flush) begin
                    state_d = ST_WORD_START;
                    lane_d  = '0;
                end else if (dev_fire) begin
                    if (last_lane) begin
                        state_d = ST_WORD_START;
                        lane_d  = '0;
                    end else begin
                        lane_d = lane_q + 1'b1;
                    end
                end
            end
        endcase
    end

    // Outputs and store control
    always_comb begin
        mem_in_ready  = to_dev && !fifo_full;
        dev_out_valid = to_dev && !fifo_empty && !flush;
        dev_in_ready  = !to_dev && !fifo_full && !flush;
        mem_out_valid = !to_dev && !fifo_empty;
        mem_out_data  = fifo_head;

        dev_fire_out  = dev_out_valid && dev_out_ready;
        dev_fire_in   = dev_in_valid && dev_in_ready;
        dev_fire      = dev_fire_out || dev_fire_in;

        if (to_dev) begin
            fifo_wdata = mem_in_data;
            fifo_push  = mem_in_valid && mem_in_ready;
            fifo_pop   = (dev_fire_out && last_lane)
                       || (flush && (state_q == ST_WORD_MID) && !fifo_empty);
        end else begin
            fifo_wdata = packed_word;
            fifo_push  = dev_fire_in && last_lane;
            fifo_pop   = mem_out_valid && mem_out_ready;
        end
    end

endmodule

// File: rtl/width_pack_buffer_checker.sv
module width_pack_buffer_checker #(
    parameter int DEPTH = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       dir,
    input logic                       half_mode,
    input logic                       big_endian,
    input logic                       flush,
    input logic                       mem_in_ready,
    input logic                       mem_out_valid,
    input logic                       dev_out_valid,
    input logic                       dev_out_ready,
    input logic [15:0]                dev_out_data,
    input logic                       dev_in_ready,
    input logic [$clog2(DEPTH+1)-1:0] fill_count,
    input logic [1:0]                 lane_q
);
    localparam int CW = $clog2(DEPTH+1);

    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        fill_count <= CW'(DEPTH));

    a_r7_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_count == CW'(DEPTH)) |-> (!mem_in_ready && !dev_in_ready));

    a_r8_empty_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_count == '0) |-> (!dev_out_valid && !mem_out_valid));

    a_r13_to_dev_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !dir |-> (!mem_out_valid && !dev_in_ready));

    a_r13_to_mem_gate: assert property (@(posedge clk) disable iff (!rst_n)
        dir |-> (!mem_in_ready && !dev_out_valid));

    a_r9_flush_lane_zero: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (lane_q == 2'd0));

    a_r10_flush_blocks_dev: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> (!dev_out_valid && !dev_in_ready));

    a_r12_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_out_valid && !dev_out_ready) |=>
            (flush || dir || !$stable(half_mode) || !$stable(big_endian)
             || (dev_out_valid && $stable(dev_out_data))));

endmodule

bind width_pack_buffer width_pack_buffer_checker #(.DEPTH(DEPTH)) u_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .dir           (dir),
    .half_mode     (half_mode),
    .big_endian    (big_endian),
    .flush         (flush),
    .mem_in_ready  (mem_in_ready),
    .mem_out_valid (mem_out_valid),
    .dev_out_valid (dev_out_valid),
    .dev_out_ready (dev_out_ready),
    .dev_out_data  (dev_out_data),
    .dev_in_ready  (dev_in_ready),
    .fill_count    (fill_count),
    .lane_q        (lane_q)
);

// File: tb/width_pack_buffer_bench.sv
module width_pack_buffer_bench;

    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dir = 1'b0, half_mode = 1'b0, big_endian = 1'b0, flush = 1'b0;
    logic        mem_in_valid = 1'b0, mem_out_ready = 1'b0;
    logic        dev_out_ready = 1'b0, dev_in_valid = 1'b0;
    logic [31:0] mem_in_data = '0;
    logic [15:0] dev_in_data = '0;
    logic        mem_in_ready, mem_out_valid, dev_out_valid, dev_in_ready;
    logic [31:0] mem_out_data;
    logic [15:0] dev_out_data;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    width_pack_buffer #(.DEPTH(DEPTH)) u_width_pack_buffer (
        .clk(clk), .rst_n(rst_n), .dir(dir), .half_mode(half_mode),
        .big_endian(big_endian), .flush(flush),
        .mem_in_valid(mem_in_valid), .mem_in_ready(mem_in_ready), .mem_in_data(mem_in_data),
        .mem_out_valid(mem_out_valid), .mem_out_ready(mem_out_ready), .mem_out_data(mem_out_data),
        .dev_out_valid(dev_out_valid), .dev_out_ready(dev_out_ready), .dev_out_data(dev_out_data),
        .dev_in_valid(dev_in_valid), .dev_in_ready(dev_in_ready), .dev_in_data(dev_in_data)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [31:0] tx_word(input int i);
        return 32'h1F2E3D4C ^ (32'(i) * 32'h11223344);
    endfunction

    function automatic logic [15:0] rx_item(input int j);
        return {8'(j * 37 + 5), 8'(j * 11 + 3)};
    endfunction

    // Expected item k of a word, from the lane mapping requirements.
    function automatic logic [15:0] exp_item(input logic [31:0] w, input int k,
                                             input logic h, input logic e);
        int n = h ? 2 : 4;
        int p = e ? (n - 1 - k) : k;
        return h ? 16'((w >> (16 * p)) & 32'hFFFF) : 16'((w >> (8 * p)) & 32'hFF);
    endfunction

    function automatic logic [31:0] exp_word(input int base, input logic h, input logic e);
        int n = h ? 2 : 4;
        logic [31:0] w = '0;
        for (int k = 0; k < n; k++) begin
            int p = e ? (n - 1 - k) : k;
            logic [15:0] it = rx_item(base + k);
            if (h) w = w | (32'(it) << (16 * p));
            else   w = w | (32'(it[7:0]) << (8 * p));
        end
        return w;
    endfunction

    task automatic run_tx(input logic h, input logic e);
        int n = h ? 2 : 4;
        string tag = h ? "R4/R11" : (e ? "R3/R11" : "R2/R11");
        dir = 1'b0; half_mode = h; big_endian = e;
        for (int i = 0; i < DEPTH; i++) begin
            mem_in_valid = 1'b1;
            mem_in_data  = tx_word(i);
            #1 chk("R7 room before full", 32'(mem_in_ready), 32'd1);
            tick();
        end
        mem_in_valid = 1'b0;
        #1;
        chk("R7 full store blocks memory", 32'(mem_in_ready), 32'd0);
        chk("R13 to-device gates memory out", 32'(mem_out_valid), 32'd0);
        chk("R13 to-device gates device in", 32'(dev_in_ready), 32'd0);
        chk("R12 stall data", 32'(dev_out_data), 32'(exp_item(tx_word(0), 0, h, e)));
        tick();
        #1 chk("R12 stall data held", 32'(dev_out_data), 32'(exp_item(tx_word(0), 0, h, e)));
        dev_out_ready = 1'b1;
        for (int i = 0; i < DEPTH; i++) begin
            for (int k = 0; k < n; k++) begin
                #1;
                chk(tag, {dev_out_valid, 15'd0, dev_out_data},
                    {1'b1, 15'd0, exp_item(tx_word(i), k, h, e)});
                tick();
            end
        end
        dev_out_ready = 1'b0;
        #1 chk("R8 empty store no device valid", 32'(dev_out_valid), 32'd0);
    endtask

    task automatic run_rx(input logic h, input logic e);
        int n = h ? 2 : 4;
        string tag = h ? "R6" : "R5";
        dir = 1'b1; half_mode = h; big_endian = e;
        for (int i = 0; i < DEPTH; i++) begin
            for (int k = 0; k < n; k++) begin
                dev_in_valid = 1'b1;
                dev_in_data  = rx_item(i * n + k);
                #1;
                chk("R7 device room", 32'(dev_in_ready), 32'd1);
                chk({tag, " whole words only"}, 32'(mem_out_valid), 32'(i != 0));
                tick();
            end
        end
        dev_in_valid = 1'b0;
        #1;
        chk("R7 full store blocks device", 32'(dev_in_ready), 32'd0);
        chk("R13 to-memory gates memory in", 32'(mem_in_ready), 32'd0);
        chk("R13 to-memory gates device out", 32'(dev_out_valid), 32'd0);
        mem_out_ready = 1'b1;
        for (int i = 0; i < DEPTH; i++) begin
            #1 chk({tag, "/R11 packed word"}, mem_out_data, exp_word(i * n, h, e));
            tick();
        end
        mem_out_ready = 1'b0;
        #1 chk("R8 empty store no memory valid", 32'(mem_out_valid), 32'd0);
    endtask

    initial begin
        #(8 * 150000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 reset mem_in_ready", 32'(mem_in_ready), 32'd1);
        chk("R1 reset dev_out_valid", 32'(dev_out_valid), 32'd0);
        chk("R1 reset mem_out_valid", 32'(mem_out_valid), 32'd0);
        chk("R1 reset dev_in_ready", 32'(dev_in_ready), 32'd0);
        dir = 1'b1;
        #1;
        chk("R1 reset dev_in_ready dir=1", 32'(dev_in_ready), 32'd1);
        chk("R1 reset mem_in_ready dir=1", 32'(mem_in_ready), 32'd0);
        @(negedge clk);

        for (int c = 0; c < 4; c++) run_tx(c[1], c[0]);
        for (int c = 0; c < 4; c++) run_rx(c[1], c[0]);

        // R9: flush mid-word toward memory, byte mode, low-end first
        dir = 1'b1; half_mode = 1'b0; big_endian = 1'b0;
        for (int k = 0; k < 2; k++) begin
            dev_in_valid = 1'b1;
            dev_in_data  = 16'hEE00 | 16'(8'hA0 + k);
            tick();
        end
        flush = 1'b1;
        #1 chk("R9 device blocked in flush", 32'(dev_in_ready), 32'd0);
        tick();
        flush = 1'b0;
        for (int k = 0; k < 4; k++) begin
            dev_in_data = rx_item(100 + k);
            tick();
        end
        dev_in_valid = 1'b0;
        #1 chk("R9 word after flush", mem_out_data, exp_word(100, 1'b0, 1'b0));
        mem_out_ready = 1'b1;
        tick();
        mem_out_ready = 1'b0;
        #1 chk("R9 only one word formed", 32'(mem_out_valid), 32'd0);

        // R10: flush toward device, half-word mode, high-end first
        dir = 1'b0; half_mode = 1'b1; big_endian = 1'b1;
        mem_in_valid = 1'b1;
        mem_in_data  = 32'hA1B2C3D4; tick();
        mem_in_data  = 32'h5566E7F8; tick();
        mem_in_valid = 1'b0;
        dev_out_ready = 1'b1;
        #1 chk("R10 first item", 32'(dev_out_data), 32'h0000A1B2);
        tick();
        dev_out_ready = 1'b0;
        flush = 1'b1;
        #1 chk("R10 device valid dropped in flush", 32'(dev_out_valid), 32'd0);
        tick();
        flush = 1'b0;
        #1 chk("R10 mid-word flush drops head", {dev_out_valid, 15'd0, dev_out_data},
               {1'b1, 15'd0, 16'h5566});
        flush = 1'b1;
        tick();
        flush = 1'b0;
        #1 chk("R10 start flush keeps head", 32'(dev_out_data), 32'h00005566);
        dev_out_ready = 1'b1;
        tick();
        #1 chk("R10 second half", 32'(dev_out_data), 32'h0000E7F8);
        tick();
        dev_out_ready = 1'b0;
        #1 chk("R10 store drained", 32'(dev_out_valid), 32'd0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule